// File: doc/BRIEF.md
# MDIO Station Management Controller

This block is a register-mapped management master that lets a host read and write PHY registers over the two-wire MDC/MDIO bus. The host reaches it through a simple 32-bit register port with a byte offset, a write strobe, write data and combinational read data. The block turns host requests into 64-bit clause-22 frames. It drives MDC from a divided system clock and drives or releases MDIO through an output-enable. It samples the PHY's answer during the data phase of a read.

A write frame starts as soon as the host writes the write-data register. A read starts from the command register, and a scan mode keeps re-reading one PHY register and refreshing the read-data register after each frame. The indicator register tells the host when the bus is busy, when scan is on, and whether the read data is still stale. Writing zero to the command register ends the current activity at the next bit boundary.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x24 command, 0x28 address, 0x2C write data, 0x30 read data and 0x34 indicators. Any other offset reads zero, and a write to it changes nothing.
- R2: Command bit 0 requests one read and bit 1 enables scan. The register reads back the two stored bits, with all upper bits zero.
- R3: The address register holds the PHY address in bits 12:8 and the PHY register number in bits 4:0. All other bits read as zero.
- R4: A write to the write-data register stores bits 15:0, ignores bits 31:16, and queues a write frame to the addressed PHY register. The busy indicator is set from the next cycle.
- R5: Read data returns the 16 bits of the last completed read in bits 15:0, with bits 31:16 zero. It resets to zero.
- R6: Indicator bit 0 (busy) is set while a frame is pending or being shifted. Bit 1 is set while scan is enabled. Bit 2 (not valid) is set by a read or scan request and clears in the same cycle that the read data is latched, which is also the cycle in which busy clears for a lone read.
- R7: Every frame carries 32 ones, then 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address and the 5-bit register number, all MSB first. A write then drives 10 and 16 data bits MSB first. A read releases MDIO for both turnaround bits and for all 16 data bits.
- R8: MDC has a period of MDC_DIV system clocks with a 50% duty cycle (80 ns at the default of 8 with a 10 ns clock). MDIO changes only at MDC falling edges, and read bits are sampled at MDC rising edges.
- R9: While scan is enabled, the block issues read frames one after another to the addressed register and updates the read data after each frame.
- R10: A write-data or address write that arrives during a frame is accepted into its register. A queued frame starts only after the current frame ends, using the address held at its own start, and busy stays set across both frames.
- R11: Writing zero to the command register cancels queued frames and scan. It ends an active frame at the next MDC falling edge and releases MDIO. An aborted write changes nothing in the PHY, and an aborted read leaves not-valid set.
- R12: After reset MDC is low, MDIO is released, and every register and indicator reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situations to reach are those where a host write lands while a frame is mid-flight. One is an abort in the middle of a preamble or a scan frame. Another is a second write-data or address update issued while the first write frame is still being shifted. The bench reaches both by counting system clocks after the first request before it issues the second register write, so the second write always falls inside a known bit of the running frame. A bus-level PHY model then shows whether the PHY register file changed, which frame used which address, and whether the master drove MDIO while the PHY was driving it.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam int unsigned OFF_CMD    = 'h24;
  localparam int unsigned OFF_ADDR   = 'h28;
  localparam int unsigned OFF_WDATA  = 'h2C;
  localparam int unsigned OFF_RDATA  = 'h30;
  localparam int unsigned OFF_IND    = 'h34;

  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned DATA_BITS  = 16;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_FIRST   = 46;
  localparam int unsigned DATA_FIRST = 48;
  localparam int unsigned ID_W       = 5;

  localparam logic [1:0] SOF_PAT = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  assign rise_o = (cnt_q == CW'(HALF - 1));
  assign fall_o = (cnt_q == CW'(DIV - 1));
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + 1'b1;
      if (rise_o)      mdc_q <= 1'b1;
      else if (fall_o) mdc_q <= 1'b0;
    end
  end

  p_mdc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_o && !fall_o) |=> $stable(mdc_o));
  p_mdc_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> mdc_o);
  p_mdc_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 start_i,
  input  logic                 is_read_i,
  input  logic [ID_W-1:0]      phy_i,
  input  logic [ID_W-1:0]      reg_i,
  input  logic [DATA_BITS-1:0] wdata_i,
  input  logic                 abort_i,
  output logic                 accept_o,
  output logic                 active_o,
  output logic                 is_read_o,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  input  logic                 mdio_i
);
  localparam int unsigned BW = $clog2(FRAME_BITS);

  logic                  active_q, is_rd_q, mdio_q, oe_q;
  logic [BW-1:0]         bit_q;
  logic [FRAME_BITS-1:0] shift_q, frame_w;
  logic [DATA_BITS-1:0]  rx_q;
  logic                  last_bit;

  always_comb begin
    frame_w = {{PRE_BITS{1'b1}}, SOF_PAT, (is_read_i ? OP_RD : OP_WR), phy_i, reg_i,
               (is_read_i ? 2'b11 : TA_WR),
               (is_read_i ? {DATA_BITS{1'b1}} : wdata_i)};
  end

  assign last_bit  = (bit_q == BW'(FRAME_BITS - 1));
  assign accept_o  = fall_i & ~active_q & start_i;
  assign done_o    = fall_i & active_q & last_bit & ~abort_i;
  assign active_o  = active_q;
  assign is_read_o = is_rd_q;
  assign rx_data_o = rx_q;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      is_rd_q  <= 1'b0;
      mdio_q   <= 1'b1;
      oe_q     <= 1'b0;
      bit_q    <= '0;
      shift_q  <= '0;
      rx_q     <= '0;
    end else begin
      if (fall_i) begin
        if (active_q) begin
          if (abort_i || last_bit) begin
            active_q <= 1'b0;
            oe_q     <= 1'b0;
            mdio_q   <= 1'b1;
          end else begin
            bit_q   <= bit_q + 1'b1;
            shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
            mdio_q  <= shift_q[FRAME_BITS-2];
            // release from the first turnaround bit onward on reads
            oe_q    <= ~(is_rd_q && (bit_q >= BW'(TA_FIRST - 1)));
          end
        end else if (start_i) begin
          active_q <= 1'b1;
          is_rd_q  <= is_read_i;
          bit_q    <= '0;
          shift_q  <= frame_w;
          mdio_q   <= frame_w[FRAME_BITS-1];
          oe_q     <= 1'b1;
        end
      end
      if (rise_i && active_q && is_rd_q && (bit_q >= BW'(DATA_FIRST)))
        rx_q <= {rx_q[DATA_BITS-2:0], mdio_i};
    end
  end

  p_ta_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && is_rd_q && (bit_q >= BW'(TA_FIRST))) |-> !mdio_oe_o);
  p_write_driven_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !is_rd_q) |-> mdio_oe_o);
  p_idle_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !mdio_oe_o);
  p_mdio_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> ($stable(mdio_o) && $stable(mdio_oe_o)));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned MDC_DIV = 8,
  parameter int unsigned REG_AW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam logic [REG_AW-1:0] A_CMD   = REG_AW'(OFF_CMD);
  localparam logic [REG_AW-1:0] A_ADDR  = REG_AW'(OFF_ADDR);
  localparam logic [REG_AW-1:0] A_WDATA = REG_AW'(OFF_WDATA);
  localparam logic [REG_AW-1:0] A_RDATA = REG_AW'(OFF_RDATA);
  localparam logic [REG_AW-1:0] A_IND   = REG_AW'(OFF_IND);

  logic                 mdc_rise, mdc_fall;
  logic [1:0]           cmd_q;
  logic [ID_W-1:0]      phy_q, regn_q;
  logic [DATA_BITS-1:0] wdata_q, rdata_q, eng_rx;
  logic                 nv_q, wr_pend_q, rd_pend_q, abort_q;
  logic                 eng_accept, eng_active, eng_is_rd, eng_done, rd_done;
  logic                 we_cmd, we_addr, we_wdata, cmd_zero, busy, start_req;
  logic                 unused_hi;

  assign unused_hi = ^reg_wdata_i[31:16];

  assign we_cmd    = reg_we_i && (reg_addr_i == A_CMD);
  assign we_addr   = reg_we_i && (reg_addr_i == A_ADDR);
  assign we_wdata  = reg_we_i && (reg_addr_i == A_WDATA);
  assign cmd_zero  = we_cmd && (reg_wdata_i[1:0] == 2'b00);
  assign start_req = wr_pend_q | rd_pend_q | cmd_q[1];
  assign rd_done   = eng_done & eng_is_rd;
  assign busy      = eng_active | wr_pend_q | rd_pend_q;

  mdio_mdc_gen #(.DIV(MDC_DIV)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mdc_o  (mdc_o),
    .rise_o (mdc_rise),
    .fall_o (mdc_fall)
  );

  mdio_frame_eng u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (mdc_rise),
    .fall_i    (mdc_fall),
    .start_i   (start_req),
    .is_read_i (~wr_pend_q),
    .phy_i     (phy_q),
    .reg_i     (regn_q),
    .wdata_i   (wdata_q),
    .abort_i   (abort_q),
    .accept_o  (eng_accept),
    .active_o  (eng_active),
    .is_read_o (eng_is_rd),
    .done_o    (eng_done),
    .rx_data_o (eng_rx),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .mdio_i    (mdio_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      phy_q     <= '0;
      regn_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      nv_q      <= 1'b0;
      wr_pend_q <= 1'b0;
      rd_pend_q <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      abort_q <= cmd_zero | (abort_q & eng_active);
      if (eng_accept) begin
        if (wr_pend_q) wr_pend_q <= 1'b0;
        else           rd_pend_q <= 1'b0;
      end
      if (rd_done) begin
        rdata_q <= eng_rx;
        nv_q    <= 1'b0;
      end
      if (we_addr) begin
        phy_q  <= reg_wdata_i[12:8];
        regn_q <= reg_wdata_i[4:0];
      end
      if (we_wdata) begin
        wdata_q   <= reg_wdata_i[DATA_BITS-1:0];
        wr_pend_q <= 1'b1;
      end
      if (we_cmd) begin
        cmd_q <= reg_wdata_i[1:0];
        if (cmd_zero) begin
          wr_pend_q <= we_wdata;
          rd_pend_q <= 1'b0;
        end else begin
          nv_q <= 1'b1;
          if (reg_wdata_i[0]) rd_pend_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CMD:   reg_rdata_o[1:0] = cmd_q;
      A_ADDR:  begin
        reg_rdata_o[12:8] = phy_q;
        reg_rdata_o[4:0]  = regn_q;
      end
      A_WDATA: reg_rdata_o[DATA_BITS-1:0] = wdata_q;
      A_RDATA: reg_rdata_o[DATA_BITS-1:0] = rdata_q;
      A_IND:   reg_rdata_o[2:0] = {nv_q, cmd_q[1], busy};
      default: reg_rdata_o = '0;
    endcase
  end

  p_addr_resv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_ADDR) |-> ((reg_rdata_o & ~32'h0000_1F1F) == 32'h0));
  p_busy_after_wdata_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_wdata && !cmd_zero) |=> busy);
  p_rdata_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_RDATA) |-> (reg_rdata_o[31:16] == 16'h0));
  p_nv_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_q && !eng_done) |=> nv_q);
  p_nv_fall_on_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nv_q) |-> $past(rd_done));
  p_scan_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q[1] && !eng_active && mdc_fall) |-> eng_accept);
  p_abort_ends_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_q && mdc_fall) |=> !eng_active);
endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
  localparam int DIV = 8;
  localparam logic [7:0] O_CMD = 8'h24, O_ADDR = 8'h28, O_WDATA = 8'h2C,
                         O_RDATA = 8'h30, O_IND = 8'h34;
  localparam logic [4:0] PHY_ID = 5'd5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;
  logic        phy_drv = 1'b0, phy_bit = 1'b1;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign mdio_in = mdio_oe ? mdio_out : (phy_drv ? phy_bit : 1'b1);

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in));

  // PHY model
  typedef enum logic [2:0] {P_IDLE, P_ST, P_HDR, P_WR, P_RD} pst_t;
  pst_t        pst = P_IDLE;
  logic [15:0] phy_mem [32];
  int          ones = 0, idx = 0, collisions = 0, wr_frames = 0;
  logic [11:0] hdr = '0;
  logic [17:0] wsh = '0;
  logic [15:0] rd_val = '0;
  logic [1:0]  last_op = '0, last_ta = '0;

  always @(posedge mdc) begin
    case (pst)
      P_IDLE: begin
        if (mdio_oe && mdio_out) ones++;
        else if (mdio_oe && !mdio_out && ones >= 32) pst = P_ST;
        else ones = 0;
      end
      P_ST: begin
        ones = 0;
        if (mdio_oe && mdio_out) begin pst = P_HDR; idx = 0; end
        else pst = P_IDLE;
      end
      P_HDR: begin
        if (!mdio_oe) pst = P_IDLE;
        else begin
          hdr = {hdr[10:0], mdio_out};
          idx++;
          if (idx == 12) begin
            last_op = hdr[11:10];
            idx = 0;
            if (hdr[11:10] == 2'b10) begin
              pst = P_RD;
              rd_val = (hdr[9:5] == PHY_ID) ? phy_mem[hdr[4:0]] : 16'hFFFF;
            end else if (hdr[11:10] == 2'b01) pst = P_WR;
            else pst = P_IDLE;
          end
        end
      end
      P_WR: begin
        if (!mdio_oe) pst = P_IDLE;
        else begin
          wsh = {wsh[16:0], mdio_out};
          idx++;
          if (idx == 18) begin
            last_ta = wsh[17:16];
            if (hdr[9:5] == PHY_ID) phy_mem[hdr[4:0]] = wsh[15:0];
            wr_frames++;
            pst = P_IDLE;
          end
        end
      end
      P_RD: begin
        if (mdio_oe) collisions++;
        idx++;
        if (idx == 18) pst = P_IDLE;
      end
      default: pst = P_IDLE;
    endcase
  end

  always @(negedge mdc) begin
    if (pst == P_RD && hdr[9:5] == PHY_ID && idx >= 1 && idx < 18) begin
      phy_drv = 1'b1;
      phy_bit = (idx == 1) ? 1'b0 : rd_val[17-idx];
    end else begin
      phy_drv = 1'b0;
      phy_bit = 1'b1;
    end
  end

  // host helpers
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_clear(input logic [31:0] mask, input int limit, output int cyc);
    logic [31:0] v;
    cyc = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      rd(O_IND, v);
      cyc++;
      if ((v & mask) == 0) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    rd(O_IND, v);   chk("R12 ind", v, 0);
    rd(O_CMD, v);   chk("R12 cmd", v, 0);
    rd(O_ADDR, v);  chk("R12 addr", v, 0);
    rd(O_RDATA, v); chk("R5 R12 rdata", v, 0);
    chk("R12 oe", {31'b0, mdio_oe}, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(O_ADDR, 32'hFFFF_FFFF);
    rd(O_ADDR, v); chk("R3 addr fields", v, 32'h0000_1F1F);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, v);  chk("R1 unmapped read", v, 0);
    rd(8'h20, v);  chk("R1 unmapped 0x20", v, 0);
    rd(O_ADDR, v); chk("R1 no side write", v, 32'h0000_1F1F);
    rd(O_IND, v);  chk("R1 no busy", v, 0);
  endtask

  task automatic t_mdc();
    realtime t0, t1, t2;
    @(posedge mdc); t0 = $realtime;
    @(negedge mdc); t1 = $realtime;
    @(posedge mdc); t2 = $realtime;
    chk("R8 mdc high ns", int'(t1 - t0), 40);
    chk("R8 mdc period ns", int'(t2 - t0), 80);
  endtask

  task automatic t_write();
    logic [31:0] v;
    int cyc;
    wr(O_ADDR, {19'b0, PHY_ID, 3'b0, 5'd3});
    wr(O_WDATA, 32'hABCD_1234);
    rd(O_IND, v); chk("R4 busy next cycle", v, 32'h1);
    rd(O_WDATA, v); chk("R4 upper ignored", v, 32'h0000_1234);
    wait_clear(32'h1, 2000, cyc);
    chk("R4 write frame landed", {16'b0, phy_mem[3]}, 32'h1234);
    chk("R7 write opcode", {30'b0, last_op}, 32'h1);
    chk("R7 write turnaround", {30'b0, last_ta}, 32'h2);
    rd(O_IND, v); chk("R6 write leaves nv clear", v, 0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    int cyc;
    wr(O_CMD, 32'h1);
    rd(O_IND, v); chk("R6 busy+nv on read", v, 32'h5);
    rd(O_CMD, v); chk("R2 cmd readback", v, 32'h1);
    wait_clear(32'h1, 2000, cyc);
    rd(O_IND, v); chk("R6 nv clears with busy", v, 0);
    chk("R6 read spans a frame", {31'b0, cyc >= 500}, 1);
    rd(O_RDATA, v); chk("R5 read data", v, 32'h0000_1234);
    chk("R7 read opcode", {30'b0, last_op}, 32'h2);
    chk("R7 no collision", collisions, 0);
    wr(O_ADDR, {19'b0, 5'd9, 3'b0, 5'd3});
    wr(O_CMD, 32'h1);
    wait_clear(32'h5, 2000, cyc);
    rd(O_RDATA, v); chk("R5 absent PHY pulls up", v, 32'h0000_FFFF);
  endtask

  task automatic t_queue();
    logic [31:0] v;
    int cyc;
    phy_mem[4] = 16'h0; phy_mem[6] = 16'h0;
    wr(O_ADDR, {19'b0, PHY_ID, 3'b0, 5'd4});
    wr(O_WDATA, 32'h1111);
    idle(40);
    wr(O_ADDR, {19'b0, PHY_ID, 3'b0, 5'd6});
    wr(O_WDATA, 32'h2222);
    rd(O_IND, v); chk("R10 busy during queue", v, 32'h1);
    wait_clear(32'h1, 3000, cyc);
    chk("R10 busy spans both frames", {31'b0, cyc >= 900}, 1);
    chk("R10 first frame kept its address", {16'b0, phy_mem[4]}, 32'h1111);
    chk("R10 queued frame new address", {16'b0, phy_mem[6]}, 32'h2222);
  endtask

  task automatic t_scan();
    logic [31:0] v;
    int cyc;
    wr(O_ADDR, {19'b0, PHY_ID, 3'b0, 5'd3});
    wr(O_CMD, 32'h2);
    rd(O_IND, v); chk("R6 scan flags", v & 32'h6, 32'h6);
    rd(O_CMD, v); chk("R2 scan readback", v, 32'h2);
    wait_clear(32'h4, 2000, cyc);
    rd(O_RDATA, v); chk("R9 first scan value", v, 32'h0000_1234);
    phy_mem[3] = 16'hBEEF;
    idle(3 * 64 * DIV);
    rd(O_RDATA, v); chk("R9 scan refresh", v, 32'h0000_BEEF);
    rd(O_IND, v);   chk("R9 scan still on", v & 32'h6, 32'h2);
    idle(100);
    wr(O_CMD, 32'h0);
    idle(2 * DIV + 2);
    rd(O_IND, v); chk("R11 scan stopped", v, 0);
    chk("R11 mdio released", {31'b0, mdio_oe}, 0);
    idle(160 * DIV);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int cyc;
    phy_mem[7] = 16'h0;
    wr(O_ADDR, {19'b0, PHY_ID, 3'b0, 5'd7});
    wr(O_WDATA, 32'h5A5A);
    idle(100);
    wr(O_CMD, 32'h0);
    idle(2 * DIV + 2);
    rd(O_IND, v); chk("R11 write aborted", v, 0);
    chk("R11 oe low", {31'b0, mdio_oe}, 0);
    idle(80 * DIV);
    chk("R11 PHY untouched", {16'b0, phy_mem[7]}, 0);
    wr(O_CMD, 32'h1);
    idle(200);
    wr(O_CMD, 32'h0);
    idle(2 * DIV + 2);
    rd(O_IND, v); chk("R11 aborted read keeps nv", v, 32'h4);
    idle(80 * DIV);
    phy_mem[7] = 16'h0F0F;
    wr(O_CMD, 32'h1);
    wait_clear(32'h5, 2000, cyc);
    rd(O_RDATA, v); chk("R11 read after abort", v, 32'h0000_0F0F);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_mdc();
    t_write();
    t_read();
    t_queue();
    t_scan();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule